// File: doc/BRIEF.md
# Three-Bus Register and ALU Datapath

This block is the data side of a small processor core. Three internal buses link a register file, an ALU and a set of special registers. Two register-file read ports drive bus A and bus B, and one write port takes bus C, so a full register-to-register operation completes in one clock cycle. The ALU takes its first operand from bus A, or from a constant of four chosen through a multiplexer. Its second operand comes from bus B, and its result always goes out on bus C. Bus B can also carry the program counter, the memory data register or the instruction register, so those values can reach bus C through a pass mode.

The program counter has its own +4 incrementer, so it can advance while the ALU does other work. No temporary holding registers sit around the ALU. A simple memory port carries the address from the address register, a read request and a completion strobe. The completion strobe loads read data into the memory data register. A sequencer outside this block drives every per-cycle control strobe.

Top module: `tribus_datapath`

## Requirements
- R1: While reset is low, and right after it is released, the program counter, address register, instruction register, memory data register and all eight registers read zero, and the memory request output is low.
- R2: Bus A shows the register chosen by `rdSelA` and, when `busBSel` is 0, bus B shows the register chosen by `rdSelB`. Both reads are combinational and happen in the same cycle.
- R3: With `regWrEn` high, the register chosen by `wrSel` takes the bus C value at the rising edge. A read of that register in the same cycle still returns the old value.
- R4: `aluOp` picks the result on bus C: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 XOR, 5 pass A, 6 pass B, 7 zero. All arithmetic wraps modulo 2^32.
- R5: With `useConst4` high, the ALU first operand is the constant 4 instead of bus A. Bus A itself does not change.
- R6: `busBSel` picks the bus B source: 0 register read port B, 1 program counter, 2 memory data register, 3 instruction register.
- R7: With `pcInc` high, the program counter adds 4 at the edge without using the ALU. If `pcLoad` is also high, the bus C value is loaded instead.
- R8: The address, instruction and program counter registers change only at a rising edge where their load strobe (`marLoad`, `irLoad`, `pcLoad` or `pcInc`) is high. Otherwise they hold their value.
- R9: `memRead` starts a read. `memReq` is high in that cycle and in every later cycle until `memDone` arrives. `memDone` during a pending read loads `memRdata` into the memory data register and ends the read. `memDone` with no read pending does nothing.
- R10: With `mdrLoad` high, the memory data register loads bus C, unless a read completes in the same cycle. In that case the memory data wins.
- R11: A fetch-and-add runs in four cycles: (1) PC pass-B to the address register with a read and a PC increment, (2) memory completion, (3) memory data pass-B to the instruction register, (4) add of two registers into a third. At the end the instruction register holds the fetched word and the destination register holds the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdSelA | input | 3 | Register shown on bus A |
| rdSelB | input | 3 | Register shown on bus B when busBSel is 0 |
| wrSel | input | 3 | Register written from bus C |
| regWrEn | input | 1 | Register file write strobe |
| aluOp | input | 3 | ALU operation code |
| useConst4 | input | 1 | ALU first operand is 4 |
| busBSel | input | 2 | Bus B source select |
| pcLoad | input | 1 | Load program counter from bus C |
| pcInc | input | 1 | Add 4 to program counter |
| marLoad | input | 1 | Load address register from bus C |
| irLoad | input | 1 | Load instruction register from bus C |
| mdrLoad | input | 1 | Load memory data register from bus C |
| memRead | input | 1 | Start a memory read |
| memDone | input | 1 | Memory completion strobe |
| memRdata | input | 32 | Memory read data |
| memReq | output | 1 | Read outstanding |
| memAddr | output | 32 | Address register contents |
| pcQ | output | 32 | Program counter |
| irQ | output | 32 | Instruction register |
| mdrQ | output | 32 | Memory data register |
| busAQ | output | 32 | Bus A value |
| busBQ | output | 32 | Bus B value |
| busCQ | output | 32 | Bus C (ALU result) value |

## Verification
The three buses and `memReq` are combinational and depend only on the current inputs and state. They are due in the same cycle the control inputs are applied. The bench samples them a few nanoseconds after driving, and well before the next rising edge. Every register result is due at the first rising edge after its strobe. The bench moves its reference model forward at that edge and compares one nanosecond later. Register-file contents are checked a cycle later, when they are read back onto bus A and bus B.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'd0,
    ALU_SUB   = 3'd1,
    ALU_AND   = 3'd2,
    ALU_OR    = 3'd3,
    ALU_XOR   = 3'd4,
    ALU_PASSA = 3'd5,
    ALU_PASSB = 3'd6,
    ALU_ZERO  = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    BSRC_REG = 2'd0,
    BSRC_PC  = 2'd1,
    BSRC_MDR = 2'd2,
    BSRC_IR  = 2'd3
  } busBSrc_e;

  typedef struct packed {
    logic     regWe;
    logic     pcLoad;
    logic     pcInc;
    logic     marLoad;
    logic     irLoad;
    logic     mdrFromBus;
    logic     mdrFromMem;
    logic     useConst4;
    aluOp_e   aluOp;
    busBSrc_e bSrc;
  } strobes_t;

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              we,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdA,
  output logic [DATA_W-1:0] rdB
);

  logic [DATA_W-1:0] regArr [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (we && wrSel == SEL_W'(i)) q <= wrData;
    end
    assign regArr[i] = q;
  end

  // reads see the stored value, never the word being written this cycle
  assign rdA = regArr[rdSelA];
  assign rdB = regArr[rdSelB];

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(we) && rdSelA == $past(wrSel)) |-> rdA == $past(wrData));

  assert_no_write_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(we) && rdSelB == $past(rdSelB)) |-> rdB == $past(rdB));

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluOp_e            op,
  input  logic              useConst4,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] result
);

  localparam logic [DATA_W-1:0] CONST4 = DATA_W'(4);

  logic [DATA_W-1:0] opA;
  assign opA = useConst4 ? CONST4 : busA;

  always_comb begin
    unique case (op)
      ALU_ADD:   result = opA + busB;
      ALU_SUB:   result = opA - busB;
      ALU_AND:   result = opA & busB;
      ALU_OR:    result = opA | busB;
      ALU_XOR:   result = opA ^ busB;
      ALU_PASSA: result = opA;
      ALU_PASSB: result = busB;
      default:   result = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_PASSB) assert_passb_R4: assert (result == busB);
    if (op == ALU_ZERO)  assert_zero_R4: assert (result == '0);
  end

endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regWrEn,
  input  logic     pcLoad,
  input  logic     pcInc,
  input  logic     marLoad,
  input  logic     irLoad,
  input  logic     mdrLoad,
  input  logic     useConst4,
  input  logic [2:0] aluOp,
  input  logic [1:0] busBSel,
  input  logic     memRead,
  input  logic     memDone,
  output strobes_t st,
  output logic     memReq
);

  logic pendQ;
  logic readFinish;

  assign readFinish = pendQ && memDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= memRead || (pendQ && !memDone);
  end

  assign memReq = memRead || pendQ;

  always_comb begin
    st.regWe      = regWrEn;
    st.pcLoad     = pcLoad;
    st.pcInc      = pcInc;
    st.marLoad    = marLoad;
    st.irLoad     = irLoad;
    st.mdrFromMem = readFinish;
    st.mdrFromBus = mdrLoad && !readFinish;
    st.useConst4  = useConst4;
    st.aluOp      = aluOp_e'(aluOp);
    st.bSrc       = busBSrc_e'(busBSel);
  end

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone) |=> memReq);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memDone && !memRead) |=> !memReq || memRead);

  always_comb begin
    assert_mdr_single_R10: assert (!(st.mdrFromMem && st.mdrFromBus));
  end

endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] busC,
  output logic [DATA_W-1:0] pcQ,
  output logic [DATA_W-1:0] marQ,
  output logic [DATA_W-1:0] irQ,
  output logic [DATA_W-1:0] mdrQ
);

  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);

  logic [DATA_W-1:0] rfB;

  tribus_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) rf_i (
    .clk(clk), .rstN(rstN),
    .rdSelA(rdSelA), .rdSelB(rdSelB), .wrSel(wrSel),
    .we(st.regWe), .wrData(busC),
    .rdA(busA), .rdB(rfB)
  );

  always_comb begin
    unique case (st.bSrc)
      BSRC_REG: busB = rfB;
      BSRC_PC:  busB = pcQ;
      BSRC_MDR: busB = mdrQ;
      default:  busB = irQ;
    endcase
  end

  tribus_alu #(.DATA_W(DATA_W)) alu_i (
    .op(st.aluOp), .useConst4(st.useConst4),
    .busA(busA), .busB(busB), .result(busC)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      marQ <= '0;
      irQ  <= '0;
      mdrQ <= '0;
    end else begin
      if (st.pcLoad)     pcQ <= busC;
      else if (st.pcInc) pcQ <= pcQ + PC_STEP;
      if (st.marLoad)    marQ <= busC;
      if (st.irLoad)     irQ  <= busC;
      if (st.mdrFromMem)      mdrQ <= memRdata;
      else if (st.mdrFromBus) mdrQ <= busC;
    end
  end

  assert_pc_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.pcInc) && !$past(st.pcLoad)) |-> pcQ == $past(pcQ) + PC_STEP);

  assert_pc_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.pcLoad) |-> pcQ == $past(busC));

  assert_mar_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.marLoad) |-> $stable(marQ));

  assert_ir_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.irLoad) |-> $stable(irQ));

  assert_mdr_mem_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.mdrFromMem) |-> mdrQ == $past(memRdata));

endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
  import tribus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              regWrEn,
  input  logic [2:0]        aluOp,
  input  logic              useConst4,
  input  logic [1:0]        busBSel,
  input  logic              pcLoad,
  input  logic              pcInc,
  input  logic              marLoad,
  input  logic              irLoad,
  input  logic              mdrLoad,
  input  logic              memRead,
  input  logic              memDone,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] pcQ,
  output logic [DATA_W-1:0] irQ,
  output logic [DATA_W-1:0] mdrQ,
  output logic [DATA_W-1:0] busAQ,
  output logic [DATA_W-1:0] busBQ,
  output logic [DATA_W-1:0] busCQ
);

  strobes_t st;

  tribus_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .pcLoad(pcLoad), .pcInc(pcInc),
    .marLoad(marLoad), .irLoad(irLoad), .mdrLoad(mdrLoad),
    .useConst4(useConst4), .aluOp(aluOp), .busBSel(busBSel),
    .memRead(memRead), .memDone(memDone),
    .st(st), .memReq(memReq)
  );

  tribus_core #(.DATA_W(DATA_W), .REG_N(REG_N)) core_i (
    .clk(clk), .rstN(rstN), .st(st),
    .rdSelA(rdSelA), .rdSelB(rdSelB), .wrSel(wrSel),
    .memRdata(memRdata),
    .busA(busAQ), .busB(busBQ), .busC(busCQ),
    .pcQ(pcQ), .marQ(memAddr), .irQ(irQ), .mdrQ(mdrQ)
  );

endmodule

// File: tb/tribus_datapath_tb.sv
module tribus_datapath_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  raS, rbS, wcS, op;
  logic        rcWe, c4, pcL, pcI, marL, irL, mdrL, mRd, mDone;
  logic [1:0]  bSel;
  logic [31:0] rdata;
  logic        memReq;
  logic [31:0] memAddr, pcQ, irQ, mdrQ, busA, busB, busC;

  tribus_datapath dut_i (
    .clk(clk), .rstN(rstN), .rdSelA(raS), .rdSelB(rbS), .wrSel(wcS),
    .regWrEn(rcWe), .aluOp(op), .useConst4(c4), .busBSel(bSel),
    .pcLoad(pcL), .pcInc(pcI), .marLoad(marL), .irLoad(irL), .mdrLoad(mdrL),
    .memRead(mRd), .memDone(mDone), .memRdata(rdata),
    .memReq(memReq), .memAddr(memAddr), .pcQ(pcQ), .irQ(irQ), .mdrQ(mdrQ),
    .busAQ(busA), .busBQ(busB), .busCQ(busC)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] mReg [8];
  logic [31:0] mPc, mMar, mIr, mMdr;
  logic        mPend;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] aluRef(input logic [2:0] o, input logic [31:0] a,
                                         input logic [31:0] b);
    case (o)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a;
      3'd6: return b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic idle();
    raS = 0; rbS = 0; wcS = 0; op = 3'd7; rcWe = 0; c4 = 0; bSel = 0;
    pcL = 0; pcI = 0; marL = 0; irL = 0; mdrL = 0; mRd = 0; mDone = 0; rdata = 0;
  endtask

  // inputs are set before this call; combinational results are checked,
  // then registered results one ns after the next rising edge
  task automatic step();
    logic [31:0] eA, eB, eC, nPc, nMdr;
    logic nPend;
    #2;
    eA = mReg[raS];
    case (bSel)
      2'd0: eB = mReg[rbS];
      2'd1: eB = mPc;
      2'd2: eB = mMdr;
      default: eB = mIr;
    endcase
    eC = aluRef(op, c4 ? 32'd4 : eA, eB);
    chk("R2 busA", busA, eA);
    chk("R6 busB", busB, eB);
    chk("R4/R5 busC", busC, eC);
    chk("R9 memReq", {31'd0, memReq}, {31'd0, mRd | mPend});
    nPc   = pcL ? eC : (pcI ? mPc + 32'd4 : mPc);
    nMdr  = (mDone && mPend) ? rdata : (mdrL ? eC : mMdr);
    nPend = mRd | (mPend & ~mDone);
    @(posedge clk);
    #1;
    if (rcWe) mReg[wcS] = eC;
    if (marL) mMar = eC;
    if (irL)  mIr = eC;
    mPc = nPc; mMdr = nMdr; mPend = nPend;
    chk("R7 pc", pcQ, mPc);
    chk("R8 mar", memAddr, mMar);
    chk("R8 ir", irQ, mIr);
    chk("R10 mdr", mdrQ, mMdr);
  endtask

  task automatic loadReg(input logic [2:0] idx, input logic [31:0] val);
    idle(); mRd = 1; step();
    idle(); mDone = 1; rdata = val; step();
    idle(); bSel = 2'd2; op = 3'd6; rcWe = 1; wcS = idx; step();
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] oldPc, sum;
    void'($urandom(32'd20240611));
    idle();
    for (int i = 0; i < 8; i++) mReg[i] = 0;
    mPc = 0; mMar = 0; mIr = 0; mMdr = 0; mPend = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chk("R1 pc", pcQ, 0); chk("R1 mar", memAddr, 0); chk("R1 ir", irQ, 0);
    chk("R1 mdr", mdrQ, 0); chk("R1 memReq", {31'd0, memReq}, 0);
    for (int i = 0; i < 8; i++) begin
      raS = 3'(i); #1; chk("R1 reg", busA, 0);
    end
    idle();

    // R3 same-cycle read of the written register sees the old value
    loadReg(3'd3, 32'h1111_2222);
    idle(); raS = 3; rbS = 3; op = 3'd0; rcWe = 1; wcS = 3; step();
    idle(); raS = 3; #2; chk("R3 new value", busA, 32'h2222_4444);
    idle(); step();

    // R5 constant four does not touch bus A
    idle(); raS = 3; c4 = 1; op = 3'd5; step();

    // R7 load beats increment
    loadReg(3'd1, 32'h0000_1000);
    idle(); raS = 1; op = 3'd5; pcL = 1; pcI = 1; step();
    chk("R7 load priority", pcQ, 32'h0000_1000);

    // R9 completion with nothing pending is ignored
    idle(); mDone = 1; rdata = 32'hDEAD_BEEF; step();
    chk("R9 stray done", mdrQ, 32'h0000_1000);

    // R10 memory data beats bus load
    idle(); mRd = 1; step();
    idle(); mDone = 1; rdata = 32'hCAFE_0001; mdrL = 1; raS = 1; op = 3'd5; step();
    chk("R10 mem priority", mdrQ, 32'hCAFE_0001);

    // R11 fetch then add R5 + R6 into R4
    loadReg(3'd5, 32'h7000_0005);
    loadReg(3'd6, 32'h9000_0007);
    oldPc = mPc;
    sum = 32'h7000_0005 + 32'h9000_0007;
    idle(); bSel = 2'd1; op = 3'd6; marL = 1; mRd = 1; pcI = 1; step();
    idle(); mDone = 1; rdata = 32'h00A5_6004; step();
    idle(); bSel = 2'd2; op = 3'd6; irL = 1; step();
    idle(); raS = 5; rbS = 6; op = 3'd0; rcWe = 1; wcS = 4; step();
    chk("R11 mar", memAddr, oldPc);
    chk("R11 pc", pcQ, oldPc + 32'd4);
    chk("R11 ir", irQ, 32'h00A5_6004);
    idle(); raS = 4; #2; chk("R11 sum", busA, sum);
    idle(); step();

    // random traffic, all requirements through the model
    for (int n = 0; n < 3000; n++) begin
      idle();
      raS = 3'($urandom); rbS = 3'($urandom); wcS = 3'($urandom);
      op = 3'($urandom); bSel = 2'($urandom);
      rcWe = ($urandom % 3) == 0; c4 = ($urandom % 4) == 0;
      pcL = ($urandom % 8) == 0; pcI = ($urandom % 3) == 0;
      marL = ($urandom % 4) == 0; irL = ($urandom % 5) == 0;
      mdrL = ($urandom % 4) == 0; mRd = ($urandom % 6) == 0;
      mDone = ($urandom % 3) == 0; rdata = $urandom;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule